// File: doc/BRIEF.md
# Three-Phase PWM Timebase with Buffered Compares

This block is a 16-bit timebase for a three-phase motor drive. A counter runs either as a sawtooth (counts up, wraps to zero after reaching the active period) or as a triangle (counts up to the period, counts back down, and shows zero on two consecutive ticks before climbing again). Each of the three phases has a duty value. A phase output is high while the counter is below that phase's active duty.

The period and the three duties are double buffered. Software writes shadow copies over a small register bus. The active copies load only at defined counter events, so a waveform never changes in the middle of a cycle. The period loads at the top of the count in sawtooth mode and at the bottom of the count in triangle mode. A 2-bit select field chooses when the duties load. While the counter is halted, writing the period shadow also updates the active period at once. The block also outputs the counter value and one-clock event strobes for the period match and the underflow.

Bus map: address 0 is the counter (read/write); 1 is the period shadow; 2, 3 and 4 are the U, V and W duty shadows; 5 is control. Control bit 0 selects triangle mode (1) or sawtooth mode (0). Bits 2:1 are the duty reload select. Bit 3 is the read-only direction flag (1 = counting down). All other addresses and bits read as zero.

Top module: `pwm3_timebase`

## Requirements
- R1: After reset the counter, the period (active and shadow), the duties (active and shadow), the control bits and the direction flag are all zero. The phase outputs and both strobes are low.
- R2: In sawtooth mode (control bit 0 = 0), while running, the counter steps +1 on each clock. In a cycle where the counter equals the active period, `matchPulse` is high and the next value is 0.
- R3: In triangle mode (control bit 0 = 1), the counter counts up to the active period (with `matchPulse` high there) and then counts down. In the cycle where it sits at 0 while counting down, `underPulse` is high. On the next tick it shows 0 again, now counting up, and then resumes 1, 2, and so on. Control bit 3 reads 1 exactly while counting down.
- R4: With `runEn` low the counter holds its value and neither strobe is raised, even when the counter equals the period.
- R5: A bus write to the counter loads the written value and forces the up direction, even while running and counting down.
- R6: The active period loads from its shadow at a match in sawtooth mode and at an underflow in triangle mode. A shadow write while running has no effect on the count until that event.
- R7: While halted, a write to the period shadow also sets the active period in the same clock.
- R8: Reload select (control bits 2:1) is encoded as follows: 00 means the duties never load automatically; 01 means load at a match; 10 means load at an underflow; 11 means load at both events.
- R9: Phase output bit 0 (U), bit 1 (V) and bit 2 (W) is high while the counter is less than that phase's active duty. A duty of 0 gives a constant low. A duty above the period gives a constant high.
- R10: A shadow write in the same clock as a reload event loads the previous shadow value into the active register. The new value waits for the next event.
- R11: The counter, the period shadow, the three duty shadows and the control register read back on the bus at the addresses given above. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Counter runs while high |
| busAddr | input | 3 | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr` (combinational) |
| cntOut | output | 16 | Current counter value |
| matchPulse | output | 1 | High in a running cycle where the counter, counting up, equals the active period |
| underPulse | output | 1 | High in a running triangle-mode cycle where the counter sits at 0 counting down |
| phaseOut | output | 3 | Compare outputs: bit 0 U, bit 1 V, bit 2 W |

## Verification
Two functions can fall in the same clock: a software shadow write and an automatic reload. In one case the bench writes a duty shadow exactly in the cycle where the counter sits at the period with match reload selected. The U output must follow the old shadow for one full period and follow the new value only after the next match. A period shadow write in the middle of a triangle sweep is judged the same way, from the peak the counter reaches before and after the underflow. A counter write landing on a down-counting tick is also provoked, and the bench checks that the direction flag clears at once.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Register bus addresses (software-visible map)
  localparam logic [2:0] ADDR_CNT = 3'd0;
  localparam logic [2:0] ADDR_PER = 3'd1;
  localparam logic [2:0] ADDR_DU  = 3'd2;
  localparam logic [2:0] ADDR_DV  = 3'd3;
  localparam logic [2:0] ADDR_DW  = 3'd4;
  localparam logic [2:0] ADDR_CTL = 3'd5;

  localparam int PHASES = 3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic perLoad;   // active period takes its shadow
    logic dutyLoad;  // active duties take their shadows
    logic halted;    // counter not running
  } strobe_t;

endpackage

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic [CNT_W-1:0] busWrData,
  input  logic [CNT_W-1:0] perAct,
  output logic [CNT_W-1:0] cnt,
  output logic             dirDown,
  output logic             triMode,
  output logic [1:0]       reloadSel,
  output logic             matchEv,
  output logic             underEv,
  output strobe_t          strb
);

  logic             cntWr;
  logic             ctlWr;
  logic [CNT_W-1:0] cntNext;
  logic             dirNext;

  assign cntWr = busWrEn && (busAddr == ADDR_CNT);
  assign ctlWr = busWrEn && (busAddr == ADDR_CTL);

  assign matchEv = runEn && !dirDown && (cnt == perAct);
  assign underEv = runEn && triMode && dirDown && (cnt == '0);

  // Next count/direction when no software override applies
  always_comb begin
    cntNext = cnt;
    dirNext = dirDown;
    if (runEn) begin
      if (!triMode) begin
        dirNext = 1'b0;
        cntNext = matchEv ? '0 : cnt + 1'b1;
      end else if (!dirDown) begin
        if (matchEv) begin
          dirNext = 1'b1;
          cntNext = (cnt == '0) ? '0 : cnt - 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end else if (cnt == '0) begin
        dirNext = 1'b0;           // zero shown again on the turnaround tick
        cntNext = '0;
      end else begin
        cntNext = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      dirDown   <= 1'b0;
      triMode   <= 1'b0;
      reloadSel <= 2'b00;
    end else begin
      if (ctlWr) begin
        triMode   <= busWrData[0];
        reloadSel <= busWrData[2:1];
      end
      cnt     <= cntWr ? busWrData : cntNext;
      dirDown <= (cntWr || (ctlWr && !busWrData[0])) ? 1'b0 : dirNext;
    end
  end

  assign strb.perLoad  = triMode ? underEv : matchEv;
  assign strb.dutyLoad = (reloadSel[0] && matchEv) || (reloadSel[1] && underEv);
  assign strb.halted   = !runEn;

  // R2: sawtooth wraps to zero after the period match
  a_r2_saw_wrap: assert property (@(posedge clk) disable iff (!rstN)
    runEn && !triMode && (cnt == perAct) && !cntWr && !ctlWr |=> cnt == '0);

  // R3: triangle turns down at the period
  a_r3_turn_down: assert property (@(posedge clk) disable iff (!rstN)
    runEn && triMode && !dirDown && (cnt == perAct) && !cntWr && !ctlWr |=> dirDown);

  // R3: underflow repeats zero while turning up
  a_r3_double_zero: assert property (@(posedge clk) disable iff (!rstN)
    underEv && !cntWr && !ctlWr |=> (cnt == '0) && !dirDown);

  // R4: halted counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !cntWr |=> $stable(cnt));

  // R5: counter write loads value and forces up
  a_r5_wr_up: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> !dirDown && (cnt == $past(busWrData)));

endmodule

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   busAddr,
  input  logic                         busWrEn,
  input  logic [CNT_W-1:0]             busWrData,
  input  strobe_t                      strb,
  input  logic [CNT_W-1:0]             cnt,
  output logic [CNT_W-1:0]             perAct,
  output logic [CNT_W-1:0]             perBuf,
  output logic [PHASES-1:0][CNT_W-1:0] dutyBuf,
  output logic [PHASES-1:0]            phaseOut
);

  logic                         perWr;
  logic [PHASES-1:0][CNT_W-1:0] dutyAct;

  assign perWr = busWrEn && (busAddr == ADDR_PER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBuf <= '0;
      perAct <= '0;
    end else begin
      if (perWr) perBuf <= busWrData;
      if (perWr && strb.halted) perAct <= busWrData;
      else if (strb.perLoad)    perAct <= perBuf;
    end
  end

  // R7: halted shadow write reaches the active period
  a_r7_direct: assert property (@(posedge clk) disable iff (!rstN)
    perWr && strb.halted |=> perAct == $past(busWrData));

  // R6: period reload takes the pre-write shadow
  a_r6_per_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.perLoad && !strb.halted |=> perAct == $past(perBuf));

  // R6: no event, no halted write: active period unchanged
  a_r6_per_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.perLoad && !(perWr && strb.halted) |=> $stable(perAct));

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    logic dutyWr;
    assign dutyWr = busWrEn && (busAddr == ADDR_DU + 3'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyBuf[g] <= '0;
        dutyAct[g] <= '0;
      end else begin
        if (dutyWr)        dutyBuf[g] <= busWrData;
        if (strb.dutyLoad) dutyAct[g] <= dutyBuf[g];
      end
    end

    assign phaseOut[g] = cnt < dutyAct[g];

    // R8: without a reload strobe the active duty holds
    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strb.dutyLoad |=> $stable(dutyAct[g]));

    // R10: reload takes the shadow as it was before a same-cycle write
    a_r10_duty_old: assert property (@(posedge clk) disable iff (!rstN)
      strb.dutyLoad |=> dutyAct[g] == $past(dutyBuf[g]));
  end

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic [CNT_W-1:0] cntOut,
  output logic             matchPulse,
  output logic             underPulse,
  output logic [2:0]       phaseOut
);

  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             perAct;
  logic [CNT_W-1:0]             perBuf;
  logic [PHASES-1:0][CNT_W-1:0] dutyBuf;
  logic                         dirDown;
  logic                         triMode;
  logic [1:0]                   reloadSel;
  strobe_t                      strb;

  pwm3_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .perAct(perAct), .cnt(cnt), .dirDown(dirDown), .triMode(triMode),
    .reloadSel(reloadSel), .matchEv(matchPulse), .underEv(underPulse),
    .strb(strb)
  );

  pwm3_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb), .cnt(cnt), .perAct(perAct), .perBuf(perBuf),
    .dutyBuf(dutyBuf), .phaseOut(phaseOut)
  );

  assign cntOut = cnt;

  // R11: read map
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CNT: busRdData = cnt;
      ADDR_PER: busRdData = perBuf;
      ADDR_CTL: busRdData[3:0] = {dirDown, reloadSel, triMode};
      default: begin
        for (int p = 0; p < PHASES; p++)
          if (busAddr == ADDR_DU + 3'(p)) busRdData = dutyBuf[p];
      end
    endcase
  end

endmodule

// File: tb/test_pwm3_timebase.sv
module test_pwm3_timebase;
  import pwm3_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [2:0]  busAddr = ADDR_CTL;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [15:0] cntOut;
  logic        matchPulse;
  logic        underPulse;
  logic [2:0]  phaseOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  pwm3_timebase i_pwm3_timebase (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .cntOut(cntOut),
    .matchPulse(matchPulse), .underPulse(underPulse), .phaseOut(phaseOut)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = ADDR_CTL;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdData);
    busAddr = ADDR_CTL;
  endtask

  // start of each run-loop iteration: clear pending write, settle, sample
  task automatic tick();
    @(negedge clk);
    busWrEn = 1'b0; busAddr = ADDR_CTL;
    #1;
  endtask

  task automatic drive_wr(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 counter", int'(cntOut), 0);
    chk("R1 phases", int'(phaseOut), 0);
    chk("R1 strobes", int'({matchPulse, underPulse}), 0);
    rd(ADDR_CTL, v); chk("R1 control", v, 0);
    rd(ADDR_PER, v); chk("R1 period shadow", v, 0);
    rd(ADDR_DW, v);  chk("R1 duty W shadow", v, 0);
  endtask

  task automatic t_duty_none();
    int vals[6] = '{1, 2, 3, 4, 0, 1};
    wr(ADDR_CTL, 16'h0); wr(ADDR_PER, 16'd4);
    wr(ADDR_DU, 16'd2); wr(ADDR_DV, 16'd0); wr(ADDR_DW, 16'd7);
    wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R2 count", int'(cntOut), vals[i]);
      chk("R8 select 00 no reload", int'(phaseOut), 0);
    end
    runEn = 1'b0;
  endtask

  task automatic t_duty_match();
    int vals[10] = '{1, 2, 3, 4, 0, 1, 2, 3, 4, 0};
    int exp;
    wr(ADDR_CTL, 16'h2); wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      exp = (i >= 4) ? (4 | (vals[i] < 2 ? 1 : 0)) : 0;
      chk("R8 R9 match reload phases", int'(phaseOut), exp);
    end
    runEn = 1'b0;
  endtask

  task automatic t_saw();
    int vals[9]  = '{1, 2, 3, 4, 0, 1, 2, 0, 1};
    int match[9] = '{0, 0, 0, 1, 0, 0, 1, 0, 0};
    wr(ADDR_CTL, 16'h2); wr(ADDR_PER, 16'd4); wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick();
      chk("R2 R7 sawtooth count", int'(cntOut), vals[i]);
      chk("R2 match pulse", int'(matchPulse), match[i]);
      chk("R6 no underflow in sawtooth", int'(underPulse), 0);
      if (i == 0) drive_wr(ADDR_PER, 16'd2);
    end
    runEn = 1'b0;
  endtask

  task automatic t_halt();
    wr(ADDR_CNT, 16'd2);
    #1;
    chk("R4 no match while halted", int'(matchPulse), 0);
    repeat (3) @(negedge clk);
    chk("R4 halted hold", int'(cntOut), 2);
  endtask

  task automatic t_tri();
    int vals[13]  = '{1, 2, 3, 2, 1, 0, 0, 1, 2, 3, 4, 5, 4};
    int dir[13]   = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1};
    int match[13] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    int under[13] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0};
    wr(ADDR_CTL, 16'h5); wr(ADDR_PER, 16'd3); wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 13; i++) begin
      tick();
      chk("R3 R6 triangle count", int'(cntOut), vals[i]);
      chk("R3 direction flag", int'(busRdData[3]), dir[i]);
      chk("R3 match pulse", int'(matchPulse), match[i]);
      chk("R3 underflow pulse", int'(underPulse), under[i]);
      if (i == 0) drive_wr(ADDR_PER, 16'd5);
    end
    runEn = 1'b0;
  endtask

  task automatic t_duty_under();
    int vals[10] = '{1, 2, 3, 2, 1, 0, 0, 1, 2, 3};
    int act;
    wr(ADDR_CTL, 16'h5); wr(ADDR_PER, 16'd3); wr(ADDR_DU, 16'd3);
    wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      act = (i < 6) ? 2 : 3;
      chk("R8 select 10 underflow reload U", int'(phaseOut[0]), (vals[i] < act) ? 1 : 0);
    end
    runEn = 1'b0;
  endtask

  task automatic t_duty_both();
    int vals[8] = '{1, 2, 3, 2, 1, 0, 0, 1};
    int act;
    wr(ADDR_CTL, 16'h7); wr(ADDR_DU, 16'd1); wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      act = (i < 3) ? 3 : ((i < 6) ? 1 : 2);
      chk("R8 select 11 both reload U", int'(phaseOut[0]), (vals[i] < act) ? 1 : 0);
      if (i == 3) drive_wr(ADDR_DU, 16'd2);
    end
    runEn = 1'b0;
  endtask

  task automatic t_same_cycle();
    int vals[13] = '{1, 2, 3, 4, 0, 1, 2, 3, 4, 0, 1, 2, 3};
    int act;
    wr(ADDR_CTL, 16'h2); wr(ADDR_PER, 16'd4); wr(ADDR_DU, 16'd1);
    wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 13; i++) begin
      tick();
      act = (i <= 3) ? 2 : ((i <= 8) ? 1 : 3);
      chk("R10 same-cycle write and reload U", int'(phaseOut[0]), (vals[i] < act) ? 1 : 0);
      if (i == 3) drive_wr(ADDR_DU, 16'd3);
    end
    runEn = 1'b0;
  endtask

  task automatic t_cnt_write();
    int vals[7] = '{1, 2, 3, 2, 1, 2, 3};
    int dir[7]  = '{0, 0, 0, 1, 0, 0, 0};
    wr(ADDR_CTL, 16'h1); wr(ADDR_PER, 16'd3); wr(ADDR_CNT, 16'd0);
    runEn = 1'b1;
    for (int i = 0; i < 7; i++) begin
      tick();
      chk("R5 count after write", int'(cntOut), vals[i]);
      chk("R5 direction after write", int'(busRdData[3]), dir[i]);
      if (i == 3) drive_wr(ADDR_CNT, 16'd1);
    end
    runEn = 1'b0;
  endtask

  task automatic t_readback();
    int v;
    wr(ADDR_PER, 16'h1234); wr(ADDR_DU, 16'hABCD);
    wr(ADDR_DV, 16'h0F0F);  wr(ADDR_DW, 16'h8001);
    wr(ADDR_CTL, 16'h6);    wr(ADDR_CNT, 16'h0055);
    rd(ADDR_PER, v); chk("R11 period shadow", v, 'h1234);
    rd(ADDR_DU, v);  chk("R11 duty U", v, 'hABCD);
    rd(ADDR_DV, v);  chk("R11 duty V", v, 'h0F0F);
    rd(ADDR_DW, v);  chk("R11 duty W", v, 'h8001);
    rd(ADDR_CTL, v); chk("R11 control", v, 6);
    rd(ADDR_CNT, v); chk("R11 counter", v, 'h55);
    rd(3'd7, v);     chk("R11 unused address", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_duty_none();
    t_duty_match();
    t_saw();
    t_halt();
    t_tri();
    t_duty_under();
    t_duty_both();
    t_same_cycle();
    t_cnt_write();
    t_readback();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule